// File: doc/BRIEF.md
# Selectable Reference Divider Chain

This block turns a 12 MHz crystal reference into the comparison frequency that a frequency synthesizer's phase detector needs. A 2-bit code selects 10 kHz, 12.5 kHz, 25 kHz or 100 kHz. Each divide period ends with a one-cycle pulse on `cmp_pulse`. The same input also drives two side outputs. `ctl_clk` is a 2 MHz square wave for an external controller. `tod_tick` is a 50 Hz tick for a time-of-day clock.

The block runs on the system clock `clk`. The reference arrives as a clock enable: each cycle with `ref_en` high counts as one reference edge. A common prescaler divides the reference down to a 100 kHz base. A fixed decade stage turns that base into 10 kHz, and a divide-by-200 stage turns the 10 kHz into 50 Hz. The rate stage counts base ticks against the selected multiplier. A new code is taken only when a period ends, so no period is ever cut short.

`standby` parks the rate stage. The 50 Hz chain and the controller clock keep running while it is parked. In test mode the chain can be advanced one edge at a time from two step inputs, so slow dividers can be exercised without waiting for the real reference.

Top module: `refdiv_chain`

## Requirements
- R1: While `rst_n` is low, `cmp_pulse`, `ctl_clk` and `tod_tick` are 0 and every divider count is 0. The latched rate code resets to 00.
- R2: With `standby` and `test_mode` low, `cmp_pulse` is high for exactly one cycle per period. The period is measured in counted reference edges: 1200 for code 00, 960 for code 01, 480 for code 10 and 120 for code 11. The pulse appears in the cycle after the edge that completes the period.
- R3: A new `rate_sel` value is latched only at the end of a period, or while `standby` is high. The period already in progress always completes with the old ratio.
- R4: `ctl_clk` toggles once for every 3 cycles with `ref_en` high, giving a divide-by-6 square wave. The toggle is visible in the cycle after the third edge, and the output is unaffected by `test_mode`, `standby` and the step inputs.
- R5: `tod_tick` is a one-cycle pulse after every 200 ticks of the 10 kHz stage. In normal mode this is once every 240000 reference edges.
- R6: While `standby` is high, the rate counter is held at 0, `rate_sel` is latched continuously and `cmp_pulse` stays low. The prescaler, the 10 kHz and 50 Hz stages and `ctl_clk` keep counting.
- R7: While `test_mode` is high, `ref_en` has no effect on the prescaler, the rate stage or the decade stage. Each rising edge of `step_fast` counts there as one reference edge instead.
- R8: While `test_mode` is high, each rising edge of `step_slow` advances the 50 Hz divider by one step, and ticks of the 10 kHz stage do not reach it. A step input held high counts only once.
- R9: While `test_mode` is low, `step_fast` and `step_slow` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One 12 MHz reference edge per cycle when high |
| rate_sel | input | 2 | Comparison-rate code: 00 gives 10 kHz, 01 gives 12.5 kHz, 10 gives 25 kHz, 11 gives 100 kHz |
| standby | input | 1 | Parks the rate stage; the side outputs keep running |
| test_mode | input | 1 | Lets the step inputs drive the chain |
| step_fast | input | 1 | Test step: each rising edge is one reference edge for the main chain |
| step_slow | input | 1 | Test step: each rising edge advances the 50 Hz divider by one |
| cmp_pulse | output | 1 | One-cycle pulse per completed comparison period |
| ctl_clk | output | 1 | Controller clock: reference divided by 6 |
| tod_tick | output | 1 | One-cycle 50 Hz time-of-day tick |

## Verification
For each code, the comparison period is measured with `ref_en` held high, so the gap between pulses in cycles equals the ratio. This separates the four ratios and catches any swap between codes.

A code change in the middle of a period must give one old-length gap followed by new-length gaps. This pattern distinguishes a deferred switch from an immediate one.

Randomly thinned `ref_en`, toggled `standby`, and step activity in both modes are compared cycle by cycle against a reference model in the bench. Step edges in normal mode must leave every output unchanged, which separates correct gating from leakage of the step inputs. Held and repeated `step_slow` edges confirm that the 50 Hz divider counts rising edges, not levels.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   typedef logic [1:0] rate_code_t;

   // Largest of four multipliers, used to size the rate counter.
   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   // Bits needed to hold values 0 .. n-1, at least one bit.
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/refdiv_count.sv
// Modulo-MOD counter advanced by an enable; term is high on the enabled terminal step.
module refdiv_count #(
   parameter int unsigned MOD = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic term
);
   localparam int unsigned W = refdiv_pkg::cnt_bits(MOD);
   localparam logic [W-1:0] LAST = W'(MOD - 1);

   logic [W-1:0] cnt_q;

   generate
      if (MOD < 2) begin : g_bad_mod
         $error("refdiv_count: MOD must be at least 2");
      end
   endgenerate

   assign term = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (term)
         cnt_q <= '0;
      else if (en)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/refdiv_edge.sv
// Rising-edge detector for a step input.
module refdiv_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic prev_q;

   assign rise = din && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= din;
   end
endmodule

// File: rtl/refdiv_rate_stage.sv
// Counts base ticks against a code-selected multiplier; the code is re-latched only at period end.
module refdiv_rate_stage #(
   parameter int unsigned MULT_00 = 10,
   parameter int unsigned MULT_01 = 8,
   parameter int unsigned MULT_10 = 4,
   parameter int unsigned MULT_11 = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hold,
   input  refdiv_pkg::rate_code_t sel,
   input  logic                   base_tick,
   output logic                   pulse
);
   localparam int unsigned MAXM = refdiv_pkg::max_of4(MULT_00, MULT_01, MULT_10, MULT_11);
   localparam int unsigned RW   = refdiv_pkg::cnt_bits(MAXM);
   localparam int unsigned NCODE = 4;

   logic [RW-1:0]          last_tab [NCODE];
   logic [RW-1:0]          cnt_q;
   refdiv_pkg::rate_code_t code_q;
   logic                   term;

   generate
      for (genvar i = 0; i < NCODE; i++) begin : g_tab
         localparam int unsigned M = (i == 0) ? MULT_00 :
                                     (i == 1) ? MULT_01 :
                                     (i == 2) ? MULT_10 : MULT_11;
         if (M < 1) begin : g_bad_mult
            $error("refdiv_rate_stage: every multiplier must be at least 1");
         end
         assign last_tab[i] = RW'(M - 1);
      end
   endgenerate

   assign term = base_tick && (cnt_q == last_tab[code_q]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         code_q <= '0;
         pulse  <= 1'b0;
      end else if (hold) begin
         cnt_q  <= '0;
         code_q <= sel;
         pulse  <= 1'b0;
      end else begin
         pulse <= term;
         if (term) begin
            cnt_q  <= '0;
            code_q <= sel;
         end else if (base_tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain #(
   parameter int unsigned PRE_DIV  = 120,
   parameter int unsigned DEC_DIV  = 10,
   parameter int unsigned TOD_DIV  = 200,
   parameter int unsigned CTL_HALF = 3,
   parameter int unsigned MULT_00  = 10,
   parameter int unsigned MULT_01  = 8,
   parameter int unsigned MULT_10  = 4,
   parameter int unsigned MULT_11  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic [1:0] rate_sel,
   input  logic       standby,
   input  logic       test_mode,
   input  logic       step_fast,
   input  logic       step_slow,
   output logic       cmp_pulse,
   output logic       ctl_clk,
   output logic       tod_tick
);
   logic fast_rise, slow_rise;
   logic main_en, base_tick, dec_tick, slow_en, slow_term, ctl_term;

   generate
      if (PRE_DIV < 2) begin : g_bad_pre
         $error("refdiv_chain: PRE_DIV must be at least 2");
      end
      if (TOD_DIV < 2) begin : g_bad_tod
         $error("refdiv_chain: TOD_DIV must be at least 2");
      end
   endgenerate

   refdiv_edge u_fast_edge (.clk(clk), .rst_n(rst_n), .din(step_fast), .rise(fast_rise));
   refdiv_edge u_slow_edge (.clk(clk), .rst_n(rst_n), .din(step_slow), .rise(slow_rise));

   assign main_en = test_mode ? fast_rise : ref_en;

   refdiv_count #(.MOD(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(main_en), .term(base_tick));

   refdiv_count #(.MOD(DEC_DIV)) u_dec (
      .clk(clk), .rst_n(rst_n), .en(base_tick), .term(dec_tick));

   assign slow_en = test_mode ? slow_rise : dec_tick;

   refdiv_count #(.MOD(TOD_DIV)) u_tod (
      .clk(clk), .rst_n(rst_n), .en(slow_en), .term(slow_term));

   refdiv_count #(.MOD(CTL_HALF)) u_ctl (
      .clk(clk), .rst_n(rst_n), .en(ref_en), .term(ctl_term));

   refdiv_rate_stage #(
      .MULT_00(MULT_00), .MULT_01(MULT_01), .MULT_10(MULT_10), .MULT_11(MULT_11)
   ) u_rate (
      .clk(clk), .rst_n(rst_n), .hold(standby), .sel(rate_sel),
      .base_tick(base_tick), .pulse(cmp_pulse));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_clk  <= 1'b0;
         tod_tick <= 1'b0;
      end else begin
         tod_tick <= slow_term;
         if (ctl_term) ctl_clk <= !ctl_clk;
      end
   end
endmodule

// File: rtl/refdiv_chain_checker.sv
module refdiv_chain_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ref_en,
   input logic [1:0] rate_sel,
   input logic       standby,
   input logic       test_mode,
   input logic       step_fast,
   input logic       step_slow,
   input logic       cmp_pulse,
   input logic       ctl_clk,
   input logic       tod_tick
);
   // R2: the comparison pulse lasts one cycle.
   assert_cmp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pulse |=> !cmp_pulse);

   // R5: the time-of-day tick lasts one cycle.
   assert_tod_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tod_tick |=> !tod_tick);

   // R4: the controller clock moves only after a counted reference edge.
   assert_ctl_needs_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctl_clk) |-> $past(ref_en));

   // R6: a parked rate stage gives no pulse.
   assert_standby_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> !cmp_pulse);

   // R7: in test mode, with step_fast low, nothing advances the main chain.
   assert_test_no_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !step_fast) |=> !cmp_pulse);

   // R9: in normal mode, without a reference edge, the step inputs produce no output.
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !ref_en) |=> (!cmp_pulse && !tod_tick));
endmodule

bind refdiv_chain refdiv_chain_checker u_chk (.*);

// File: tb/refdiv_chain_test.sv
module refdiv_chain_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_en = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic standby = 1'b0, test_mode = 1'b0, step_fast = 1'b0, step_slow = 1'b0;
   logic cmp_pulse, ctl_clk, tod_tick;

   int checks = 0, fails = 0;
   int cyc = 0;
   string tag = "R1";
   string tod_tag = "R5";

   always #5 clk = !clk;

   refdiv_chain uut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rate_sel(rate_sel),
      .standby(standby), .test_mode(test_mode), .step_fast(step_fast),
      .step_slow(step_slow), .cmp_pulse(cmp_pulse), .ctl_clk(ctl_clk),
      .tod_tick(tod_tick));

   function automatic int mult_of(input int code);
      case (code)
         0: return 10;
         1: return 8;
         2: return 4;
         default: return 1;
      endcase
   endfunction

   // Reference model built from the requirements.
   int m_pre, m_dec, m_slow, m_ctlc, m_rcnt, m_code;
   bit m_ctl, m_cmp, m_tod, m_sfp, m_ssp, m_en, m_base, m_dt, m_sin, m_srise;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_pre = 0; m_dec = 0; m_slow = 0; m_ctlc = 0; m_rcnt = 0; m_code = 0;
         m_ctl = 0; m_cmp = 0; m_tod = 0; m_sfp = 0; m_ssp = 0;
      end else begin
         m_en    = test_mode ? (step_fast && !m_sfp) : ref_en;
         m_srise = step_slow && !m_ssp;
         m_sfp = step_fast;
         m_ssp = step_slow;
         m_base = 0;
         if (m_en) begin
            if (m_pre == 119) begin m_pre = 0; m_base = 1; end else m_pre++;
         end
         m_dt = 0;
         if (m_base) begin
            if (m_dec == 9) begin m_dec = 0; m_dt = 1; end else m_dec++;
         end
         m_sin = test_mode ? m_srise : m_dt;
         m_tod = 0;
         if (m_sin) begin
            if (m_slow == 199) begin m_slow = 0; m_tod = 1; end else m_slow++;
         end
         if (ref_en) begin
            if (m_ctlc == 2) begin m_ctlc = 0; m_ctl = !m_ctl; end else m_ctlc++;
         end
         m_cmp = 0;
         if (standby) begin
            m_rcnt = 0; m_code = rate_sel;
         end else if (m_base) begin
            if (m_rcnt == mult_of(m_code) - 1) begin
               m_cmp = 1; m_rcnt = 0; m_code = rate_sel;
            end else m_rcnt++;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison, taken away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         check(tag, "cmp_pulse", int'(cmp_pulse), int'(m_cmp));
         check("R4", "ctl_clk", int'(ctl_clk), int'(m_ctl));
         check(tod_tag, "tod_tick", int'(tod_tick), int'(m_tod));
      end
   end

   // Watchdog: an expired run counts as a failed check.
   always @(posedge clk) begin
      if (cyc > 190000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wait_pulse(output int at);
      @(negedge clk);
      while (!cmp_pulse) @(negedge clk);
      at = cyc;
   endtask

   // R2: with ref_en held high, the gap between pulses equals the ratio.
   task automatic measure(input int code);
      int t0, t1;
      rate_sel = 2'(code);
      standby = 1'b1;
      @(negedge clk);
      standby = 1'b0;
      wait_pulse(t0);
      wait_pulse(t1);
      check("R2", $sformatf("period code %0d", code), t1 - t0, 120 * mult_of(code));
   endtask

   initial begin
      int t0, t1, t2, ticks;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: outputs are low while reset is held.
      check("R1", "cmp_pulse in reset", int'(cmp_pulse), 0);
      check("R1", "ctl_clk in reset", int'(ctl_clk), 0);
      check("R1", "tod_tick in reset", int'(tod_tick), 0);
      rst_n = 1'b1;

      // R2: each code, with ref_en held high.
      tag = "R2";
      ref_en = 1'b1;
      for (int c = 0; c < 4; c++) measure(c);

      // R3: a code change in the middle of a period waits for the period to end.
      tag = "R3";
      measure(0);
      repeat (100) @(negedge clk);
      rate_sel = 2'b11;
      wait_pulse(t0);
      wait_pulse(t1);
      wait_pulse(t2);
      check("R3", "gap after late switch", t1 - t0, 120);
      check("R3", "gap with new code", t2 - t1, 120);
      rate_sel = 2'b10;
      repeat (50) @(negedge clk);
      rate_sel = 2'b01;
      wait_pulse(t0);
      wait_pulse(t1);
      check("R3", "only code at period end counts", t1 - t0, 960);

      // R2 and R4: randomly thinned reference edges with random codes.
      tag = "R2";
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         ref_en = ($urandom % 4) != 0;
         if ($urandom % 500 == 0) rate_sel = 2'($urandom);
      end

      // R6: random standby windows.
      tag = "R6";
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         ref_en = ($urandom % 3) != 0;
         if ($urandom % 300 == 0) standby = !standby;
         if ($urandom % 200 == 0) rate_sel = 2'($urandom);
      end
      standby = 1'b0;

      // R7: test mode, with ref_en random and step_fast driving the chain.
      tag = "R7";
      test_mode = 1'b1;
      rate_sel = 2'b11;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         ref_en = $urandom % 2;
         step_fast = $urandom % 2;
      end
      step_fast = 1'b0;

      // R8: step_slow edges, including long holds, advance the 50 Hz divider.
      tod_tag = "R8";
      ticks = 0;
      for (int i = 0; i < 420; i++) begin
         @(negedge clk);
         step_slow = 1'b1;
         if (tod_tick) ticks++;
         repeat ((i % 7 == 0) ? 6 : 1) begin
            @(negedge clk);
            if (tod_tick) ticks++;
         end
         step_slow = 1'b0;
      end
      repeat (3) begin
         @(negedge clk);
         if (tod_tick) ticks++;
      end
      check("R8", "ticks over 420 slow steps", ticks, 2);

      // R9: in normal mode the step inputs are toggled and must have no effect.
      tag = "R9";
      tod_tag = "R9";
      test_mode = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         ref_en = ($urandom % 5) != 0;
         step_fast = $urandom % 2;
         step_slow = $urandom % 2;
      end
      step_fast = 1'b0;
      step_slow = 1'b0;
      ref_en = 1'b1;
      rate_sel = 2'b10;
      measure(2);

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule